// File: doc/BRIEF.md
# Configurable Parallel Bus Master

This block lets on-chip logic run byte-wide read and write cycles on an external parallel bus. Typical targets are LCD controllers, memories and other processors. It drives up to 16 address pins, an 8-bit data bus with a separate output enable, two strobe pins and up to two chip selects. A single phase sequencer serves every bus style. The strobes work either as separate read and write pulses, or as a read/write direction line paired with an enable pulse. The address bytes can be sent on the data pins with latch strobes. Chip selects can take over the two top address pins. Each control pin has its own active level.

Requests use a valid/ready channel. `req_ready` is high only while no bus cycle runs. A request is accepted on the clock edge where `req_valid` and `req_ready` are both high. A source may hold `req_valid` high while `req_ready` is low; that request then waits and is not lost. A write carries its byte with the request. A read request starts a new bus read. During the accepted read, `rd_data` still holds the byte from the previous completed read; the new byte replaces it when the read finishes. After each cycle the address register can stay the same, count up or count down. The address register can be loaded while the bus is idle. Configuration inputs must be held steady while `busy` is high.

Top module: `parbus_master`

## Requirements
- R1: `req_ready` equals the inverse of `busy`. A request accepted at edge E makes `busy` high from E for exactly N cycles, where N = L + S + (1 + W) + H. L is the number of latch phases (0, 1 or 2 for `cfg_mux` = 0, 1, 2). S, W and H are `cfg_wait_setup`, `cfg_wait_strobe` and `cfg_wait_hold`.
- R2: The phases of a cycle run in this fixed order: low-address latch, high-address latch, S setup cycles, 1+W strobe cycles, then H hold cycles.
- R3: With `cfg_strobe_mode`=0, strobe A is active only in the strobe cycles of a read, and strobe B only in the strobe cycles of a write. With `cfg_strobe_mode`=1, strobe A is active for every busy cycle of a read (it acts as the direction line), and strobe B is active in the strobe cycles of both reads and writes.
- R4: Bit i of `cfg_pol` sets the active level of one pin: 1 means active high and 0 means active low. The inactive level is the complement. The bits map as follows: bit 0 strobe A, bit 1 strobe B, bit 2 low latch, bit 3 high latch, bit 4 CS1, bit 5 CS2.
- R5: With `cfg_mux` nonzero, the following apply:
  - During the low latch phase, address bits 7:0 are driven on `pad_dout` with `pad_oe` high.
  - During the high latch phase (`cfg_mux`=2 only), address bits 15:8 are driven on `pad_dout` with `pad_oe` high.
  - `pad_addr[0]` carries the low latch strobe and `pad_addr[1]` carries the high latch strobe.
  - `pad_addr[7:2]` read 0.
  - With `cfg_mux`=2, `pad_addr[15:8]` also read 0.
  - With `cfg_mux`=0, `pad_addr` shows the address register.
- R6: With `cfg_cs1_en`, `pad_addr[14]` becomes CS1. With `cfg_cs2_en`, `pad_addr[15]` becomes CS2. Each chip select is active in every busy cycle and inactive when idle.
- R7: `pad_oe` is high in the setup, strobe and hold cycles of a write, with the write byte on `pad_dout`. `pad_oe` is also high in the latch phases. In every other cycle `pad_oe` is low and `pad_dout` reads 0.
- R8: A read samples `pad_din` on the edge that ends its last strobe cycle. `rd_data` keeps that byte until the next completed read.
- R9: At the edge that ends a cycle, the address steps according to `cfg_step`: 0 holds, 1 increments, 2 decrements. The counted width is 14 bits when CS1 is enabled, 15 bits when only CS2 is enabled, and 16 bits otherwise. The count wraps within that width, and the bits above it keep their values.
- R10: An `addr_load` pulse while idle sets the address to `addr_load_val` on the next edge. An `addr_load` pulse while busy is ignored.
- R11: After reset the block is idle. The address and `rd_data` are 0, and every control pin sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (bus idle) |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Byte from the last completed read |
| busy | output | 1 | Bus cycle in progress |
| addr_load | input | 1 | Load the address register |
| addr_load_val | input | 16 | Value to load |
| cfg_strobe_mode | input | 1 | 0 = separate read/write strobes, 1 = direction + enable |
| cfg_mux | input | 2 | 0 = no mux, 1 = low byte, 2 = full 16-bit |
| cfg_cs1_en | input | 1 | CS1 replaces address pin 14 |
| cfg_cs2_en | input | 1 | CS2 replaces address pin 15 |
| cfg_step | input | 2 | 0 = hold, 1 = increment, 2 = decrement |
| cfg_wait_setup | input | 2 | Extra setup cycles |
| cfg_wait_strobe | input | 2 | Extra strobe cycles |
| cfg_wait_hold | input | 2 | Hold cycles |
| cfg_pol | input | 6 | Per-pin active levels |
| pad_addr | output | 16 | Address / latch / chip-select pins |
| pad_dout | output | 8 | Data bus output value |
| pad_oe | output | 1 | Data bus output enable |
| pad_din | input | 8 | Data bus input value |
| pad_stb_a | output | 1 | Read strobe or direction line |
| pad_stb_b | output | 1 | Write strobe or enable strobe |

## Verification
The assertions check the following on every cycle:
- The data bus stays undriven while idle and during read strobes.
- The latch strobes and the strobe phase never overlap.
- The strobe and setup phases advance as their counters dictate.
- The address bits above the counted width never move unless loaded.
- The read byte stays stable between read samples.

Only the bench scenarios can show the full per-cycle pin picture for each mix of strobe style, mux setting, chip selects and polarity. They also show the following:
- A read captures the input on exactly its last strobe edge, because the bench changes `pad_din` on every other cycle.
- The address wraps at the right width.
- Loads issued during a cycle are ignored.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ALO   = 3'd1,
    PH_AHI   = 3'd2,
    PH_SETUP = 3'd3,
    PH_STRB  = 3'd4,
    PH_HOLD  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    STEP_KEEP = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_RSV  = 2'd3
  } step_e;

  // Active-level selection, one bit per control pin (1 = active high)
  typedef struct packed {
    logic cs2;
    logic cs1;
    logic alh;
    logic all;
    logic stb_b;
    logic stb_a;
  } pol_t;

  function automatic logic drive_level(input logic active_high, input logic act);
    return active_high ? act : ~act;
  endfunction

endpackage

// File: rtl/pbm_seq.sv
module pbm_seq
  import pbm_pkg::*;
#(
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     mux,
  input  logic [WSW-1:0] ws_setup,
  input  logic [WSW-1:0] ws_strobe,
  input  logic [WSW-1:0] ws_hold,
  output phase_e         phase,
  output logic           done,
  output logic           sample
);

  phase_e         ph_q, ph_d;
  logic [WSW-1:0] cnt_q, cnt_d;

  // Phase entered once address latching is over
  phase_e         post_ph;
  logic [WSW-1:0] post_cnt;
  // Phase entered when the strobe ends
  phase_e         tail_ph;
  logic [WSW-1:0] tail_cnt;

  always_comb begin
    if (ws_setup != '0) begin
      post_ph  = PH_SETUP;
      post_cnt = ws_setup - 1'b1;
    end else begin
      post_ph  = PH_STRB;
      post_cnt = ws_strobe;
    end
    if (ws_hold != '0) begin
      tail_ph  = PH_HOLD;
      tail_cnt = ws_hold - 1'b1;
    end else begin
      tail_ph  = PH_IDLE;
      tail_cnt = '0;
    end
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    sample = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          if (mux != 2'd0) begin
            ph_d = PH_ALO;
          end else begin
            ph_d  = post_ph;
            cnt_d = post_cnt;
          end
        end
      end
      PH_ALO: begin
        if (mux >= 2'd2) begin
          ph_d = PH_AHI;
        end else begin
          ph_d  = post_ph;
          cnt_d = post_cnt;
        end
      end
      PH_AHI: begin
        ph_d  = post_ph;
        cnt_d = post_cnt;
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STRB;
          cnt_d = ws_strobe;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STRB: begin
        if (cnt_q == '0) begin
          sample = 1'b1;
          ph_d   = tail_ph;
          cnt_d  = tail_cnt;
          done   = (ws_hold == '0);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          ph_d = PH_IDLE;
          done = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;

  assert_strobe_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STRB && cnt_q != '0) |=> (ph_q == PH_STRB));

  assert_setup_to_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SETUP && cnt_q == '0) |=> (ph_q == PH_STRB));

  assert_high_latch_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ALO && mux >= 2'd2) |=> (ph_q == PH_AHI));

endmodule

// File: rtl/pbm_addr.sv
module pbm_addr
  import pbm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic [1:0]    step_mode,
  input  logic          cs1_en,
  input  logic          cs2_en,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] ALL_ONES = '1;

  logic [AW-1:0] addr_q, mask, stepped, addr_nx;

  // Counted width: bits taken over by chip selects are left out
  always_comb begin
    if (cs1_en)      mask = ALL_ONES >> 2;
    else if (cs2_en) mask = ALL_ONES >> 1;
    else             mask = ALL_ONES;
  end

  always_comb begin
    case (step_e'(step_mode))
      STEP_INC: stepped = addr_q + 1'b1;
      STEP_DEC: stepped = addr_q - 1'b1;
      default:  stepped = addr_q;
    endcase
    addr_nx = (stepped & mask) | (addr_q & ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (step) addr_q <= addr_nx;
  end

  assign addr = addr_q;

  assert_fixed_high_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> ((addr_q & ~$past(mask)) == ($past(addr_q) & ~$past(mask))));

  assert_quiet_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr_q));

endmodule

// File: rtl/pbm_pins.sv
module pbm_pins
  import pbm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          is_rd,
  input  logic          strobe_mode,
  input  logic [1:0]    mux,
  input  logic          cs1_en,
  input  logic          cs2_en,
  input  pol_t          pol,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] pad_addr,
  output logic [DW-1:0] pad_dout,
  output logic          pad_oe,
  output logic          pad_stb_a,
  output logic          pad_stb_b
);

  localparam int HW = AW - DW;

  logic active, in_strb, lat_lo, lat_hi, data_ph, wr_data;
  logic stb_a_act, stb_b_act;

  always_comb begin
    active  = (phase != PH_IDLE);
    in_strb = (phase == PH_STRB);
    lat_lo  = (phase == PH_ALO);
    lat_hi  = (phase == PH_AHI);
    data_ph = (phase == PH_SETUP) || in_strb || (phase == PH_HOLD);
    wr_data = data_ph && !is_rd;
  end

  // Strobe styles
  always_comb begin
    if (strobe_mode) begin
      stb_a_act = active && is_rd;
      stb_b_act = in_strb;
    end else begin
      stb_a_act = in_strb && is_rd;
      stb_b_act = in_strb && !is_rd;
    end
  end

  assign pad_stb_a = drive_level(pol.stb_a, stb_a_act);
  assign pad_stb_b = drive_level(pol.stb_b, stb_b_act);

  // Data pins: address bytes in latch phases, write byte in data phases
  always_comb begin
    pad_oe = lat_lo || lat_hi || wr_data;
    if (lat_lo)       pad_dout = addr[DW-1:0];
    else if (lat_hi)  pad_dout = DW'(addr[AW-1:DW]);
    else if (wr_data) pad_dout = wdata;
    else              pad_dout = '0;
  end

  // Address pins with latch strobes and chip-select takeover
  always_comb begin
    pad_addr = addr;
    if (mux != 2'd0) begin
      pad_addr[DW-1:0] = '0;
      pad_addr[0] = drive_level(pol.all, lat_lo);
      pad_addr[1] = drive_level(pol.alh, lat_hi);
      if (mux >= 2'd2) pad_addr[AW-1:DW] = {HW{1'b0}};
    end
    if (cs1_en) pad_addr[AW-2] = drive_level(pol.cs1, active);
    if (cs2_en) pad_addr[AW-1] = drive_level(pol.cs2, active);
  end

  assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strb && is_rd) |-> !pad_oe);

  assert_latch_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lat_lo, lat_hi, stb_b_act && !strobe_mode, stb_a_act && !strobe_mode}));

endmodule

// File: rtl/parbus_master.sv
module parbus_master
  import pbm_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [DW-1:0]  req_wdata,
  output logic [DW-1:0]  rd_data,
  output logic           busy,
  input  logic           addr_load,
  input  logic [AW-1:0]  addr_load_val,
  input  logic           cfg_strobe_mode,
  input  logic [1:0]     cfg_mux,
  input  logic           cfg_cs1_en,
  input  logic           cfg_cs2_en,
  input  logic [1:0]     cfg_step,
  input  logic [WSW-1:0] cfg_wait_setup,
  input  logic [WSW-1:0] cfg_wait_strobe,
  input  logic [WSW-1:0] cfg_wait_hold,
  input  logic [5:0]     cfg_pol,
  output logic [AW-1:0]  pad_addr,
  output logic [DW-1:0]  pad_dout,
  output logic           pad_oe,
  input  logic [DW-1:0]  pad_din,
  output logic           pad_stb_a,
  output logic           pad_stb_b
);

  phase_e        phase;
  logic          start, seq_done, seq_sample;
  logic          is_rd_q;
  logic [DW-1:0] wdata_q, rd_data_q;
  logic [AW-1:0] addr;

  assign busy      = (phase != PH_IDLE);
  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_rd_q   <= 1'b0;
      wdata_q   <= '0;
      rd_data_q <= '0;
    end else begin
      if (start) begin
        is_rd_q <= !req_write;
        wdata_q <= req_wdata;
      end
      if (seq_sample && is_rd_q) rd_data_q <= pad_din;
    end
  end

  assign rd_data = rd_data_q;

  pbm_seq #(.WSW(WSW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mux       (cfg_mux),
    .ws_setup  (cfg_wait_setup),
    .ws_strobe (cfg_wait_strobe),
    .ws_hold   (cfg_wait_hold),
    .phase     (phase),
    .done      (seq_done),
    .sample    (seq_sample)
  );

  pbm_addr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_load && !busy),
    .load_val  (addr_load_val),
    .step      (seq_done),
    .step_mode (cfg_step),
    .cs1_en    (cfg_cs1_en),
    .cs2_en    (cfg_cs2_en),
    .addr      (addr)
  );

  pbm_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .is_rd       (is_rd_q),
    .strobe_mode (cfg_strobe_mode),
    .mux         (cfg_mux),
    .cs1_en      (cfg_cs1_en),
    .cs2_en      (cfg_cs2_en),
    .pol         (pol_t'(cfg_pol)),
    .addr        (addr),
    .wdata       (wdata_q),
    .pad_addr    (pad_addr),
    .pad_dout    (pad_dout),
    .pad_oe      (pad_oe),
    .pad_stb_a   (pad_stb_a),
    .pad_stb_b   (pad_stb_b)
  );

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  assert_idle_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> !pad_oe);

  assert_read_byte_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(seq_sample && is_rd_q)) |=> $stable(rd_data_q));

endmodule

// File: tb/test_parbus_master.sv
module test_parbus_master;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [7:0]  req_wdata = '0, rd_data;
  logic        busy;
  logic        addr_load = 1'b0;
  logic [15:0] addr_load_val = '0;
  logic        cfg_strobe_mode = 1'b0;
  logic [1:0]  cfg_mux = 2'd0;
  logic        cfg_cs1_en = 1'b0, cfg_cs2_en = 1'b0;
  logic [1:0]  cfg_step = 2'd0;
  logic [1:0]  cfg_wait_setup = '0, cfg_wait_strobe = '0, cfg_wait_hold = '0;
  logic [5:0]  cfg_pol = 6'h3F;
  logic [15:0] pad_addr;
  logic [7:0]  pad_dout, pad_din = '0;
  logic        pad_oe, pad_stb_a, pad_stb_b;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_addr = '0;
  logic [7:0]  exp_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parbus_master i_parbus_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wdata(req_wdata), .rd_data(rd_data), .busy(busy),
    .addr_load(addr_load), .addr_load_val(addr_load_val),
    .cfg_strobe_mode(cfg_strobe_mode), .cfg_mux(cfg_mux),
    .cfg_cs1_en(cfg_cs1_en), .cfg_cs2_en(cfg_cs2_en), .cfg_step(cfg_step),
    .cfg_wait_setup(cfg_wait_setup), .cfg_wait_strobe(cfg_wait_strobe),
    .cfg_wait_hold(cfg_wait_hold), .cfg_pol(cfg_pol),
    .pad_addr(pad_addr), .pad_dout(pad_dout), .pad_oe(pad_oe),
    .pad_din(pad_din), .pad_stb_a(pad_stb_a), .pad_stb_b(pad_stb_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic lv(input logic hi, input logic act);
    return hi ? act : ~act;
  endfunction

  function automatic int n_latch();
    return (cfg_mux == 2'd0) ? 0 : (cfg_mux == 2'd1) ? 1 : 2;
  endfunction

  // Phase codes: 0 idle, 1 low latch, 2 high latch, 3 setup, 4 strobe, 5 hold
  function automatic int phase_of(input int k);
    int r = k;
    int nl = n_latch();
    if (r < nl) return (r == 0) ? 1 : 2;
    r -= nl;
    if (r < int'(cfg_wait_setup)) return 3;
    r -= int'(cfg_wait_setup);
    if (r < 1 + int'(cfg_wait_strobe)) return 4;
    return 5;
  endfunction

  function automatic logic [15:0] step_addr(input logic [15:0] a);
    logic [15:0] m, t;
    m = cfg_cs1_en ? 16'h3FFF : cfg_cs2_en ? 16'h7FFF : 16'hFFFF;
    case (cfg_step)
      2'd1:    t = a + 16'd1;
      2'd2:    t = a - 16'd1;
      default: t = a;
    endcase
    return (t & m) | (a & ~m);
  endfunction

  function automatic logic [1:0] exp_strobes(input int ph, input logic rd);
    logic act, strb, a, b;
    act = (ph != 0); strb = (ph == 4);
    a = cfg_strobe_mode ? (act && rd) : (strb && rd);
    b = cfg_strobe_mode ? strb : (strb && !rd);
    return {lv(cfg_pol[0], a), lv(cfg_pol[1], b)};
  endfunction

  function automatic logic [15:0] exp_apins(input int ph, input logic [15:0] a);
    logic [15:0] p;
    p = a;
    if (cfg_mux != 2'd0) begin
      p[7:0] = {6'b0, lv(cfg_pol[3], ph == 2), lv(cfg_pol[2], ph == 1)};
      if (cfg_mux == 2'd2) p[15:8] = 8'h00;
    end
    if (cfg_cs1_en) p[14] = lv(cfg_pol[4], ph != 0);
    if (cfg_cs2_en) p[15] = lv(cfg_pol[5], ph != 0);
    return p;
  endfunction

  function automatic logic [8:0] exp_data(input int ph, input logic rd,
                                          input logic [15:0] a, input logic [7:0] wd);
    if (ph == 1) return {1'b1, a[7:0]};
    if (ph == 2) return {1'b1, a[15:8]};
    if (ph >= 3 && !rd) return {1'b1, wd};
    return 9'h000;
  endfunction

  task automatic check_idle(input string when);
    chk({"R11 idle strobes ", when}, 32'(pad_stb_b) | (32'(pad_stb_a) << 1), 32'(exp_strobes(0, 1'b0)));
    chk({"R6 idle address pins ", when}, 32'(pad_addr), 32'(exp_apins(0, exp_addr)));
    chk({"R7 idle data pins ", when}, {23'b0, pad_oe, pad_dout}, 32'(exp_data(0, 1'b0, exp_addr, 8'h00)));
    chk({"R1 idle ready ", when}, {30'b0, busy, req_ready}, 32'h1);
  endtask

  // One full bus cycle, checked pin by pin in every cycle
  task automatic xfer(input logic wr, input logic [7:0] wd, input logic try_load);
    int n;
    logic [7:0] din_val;
    logic [15:0] a_now;
    a_now = exp_addr;
    din_val = 8'($urandom);
    n = n_latch() + int'(cfg_wait_setup) + 1 + int'(cfg_wait_strobe) + int'(cfg_wait_hold);
    @(negedge clk);
    chk("R1 ready before request", 32'(req_ready), 32'h1);
    chk("R8 rd_data before launch", 32'(rd_data), 32'(exp_rd));
    req_valid = 1'b1; req_write = wr; req_wdata = wd;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_wdata = ~wd;
      addr_load = try_load && (k == 0);
      addr_load_val = ~a_now;
      pad_din = (k == n_latch() + int'(cfg_wait_setup) + int'(cfg_wait_strobe)) ? din_val : ~din_val;
      chk("R1 busy during cycle", {30'b0, busy, req_ready}, 32'h2);
      chk("R3 R4 strobes", 32'(pad_stb_b) | (32'(pad_stb_a) << 1), 32'(exp_strobes(phase_of(k), !wr)));
      chk("R5 R6 address pins", 32'(pad_addr), 32'(exp_apins(phase_of(k), a_now)));
      chk("R2 R7 data pins", {23'b0, pad_oe, pad_dout}, 32'(exp_data(phase_of(k), !wr, a_now, wd)));
    end
    @(negedge clk);
    addr_load = 1'b0;
    exp_addr = step_addr(a_now);
    if (!wr) exp_rd = din_val;
    chk("R1 busy ends after N cycles", 32'(busy), 32'h0);
    chk("R8 read byte", 32'(rd_data), 32'(exp_rd));
    if (try_load) chk("R10 load while busy ignored", 32'(pad_addr), 32'(exp_apins(0, exp_addr)));
    check_idle("after cycle");
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk);
    addr_load = 1'b1; addr_load_val = v;
    @(negedge clk);
    addr_load = 1'b0;
    exp_addr = v;
    chk("R10 idle load", 32'(pad_addr), 32'(exp_apins(0, exp_addr)));
  endtask

  task automatic set_cfg(input logic sm, input logic [1:0] mx, input logic c1, input logic c2,
                         input logic [1:0] st, input logic [1:0] ws, input logic [1:0] wt,
                         input logic [1:0] wh, input logic [5:0] pl);
    @(negedge clk);
    cfg_strobe_mode = sm; cfg_mux = mx; cfg_cs1_en = c1; cfg_cs2_en = c2;
    cfg_step = st; cfg_wait_setup = ws; cfg_wait_strobe = wt; cfg_wait_hold = wh;
    cfg_pol = pl;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end act=hung exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state with all pins active high
    chk("R11 reset rd_data", 32'(rd_data), 32'h0);
    chk("R11 reset address", 32'(pad_addr), 32'h0);
    check_idle("after reset");

    // Directed: plain write and read, no waits, separate strobes (R3)
    load(16'h1234);
    set_cfg(1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 6'h3F);
    xfer(1'b1, 8'hA5, 1'b0);
    xfer(1'b0, 8'h00, 1'b0);
    // Directed: maximum waits, direction+enable, active-low everywhere (R2 R3 R4)
    set_cfg(1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 2'd3, 2'd3, 2'd3, 6'h00);
    xfer(1'b0, 8'h00, 1'b1);
    xfer(1'b1, 8'h5A, 1'b1);
    // Directed: full multiplexing, both chip selects (R5 R6)
    set_cfg(1'b0, 2'd2, 1'b1, 1'b1, 2'd1, 2'd1, 2'd0, 2'd1, 6'h15);
    load(16'hABCD);
    xfer(1'b1, 8'h3C, 1'b0);
    xfer(1'b0, 8'h00, 1'b0);
    // Directed: wrap corners (R9)
    set_cfg(1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 6'h3F);
    load(16'hFFFF);
    xfer(1'b1, 8'h01, 1'b0);
    chk("R9 16-bit increment wraps", 32'(pad_addr), 32'h0000);
    set_cfg(1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 2'd0, 2'd0, 2'd0, 6'h3F);
    load(16'hC000);
    xfer(1'b1, 8'h02, 1'b0);
    xfer(1'b0, 8'h00, 1'b0);
    chk("R9 14-bit decrement keeps top bits", 32'(exp_addr), 32'hFFFE);
    set_cfg(1'b0, 2'd1, 1'b0, 1'b1, 2'd1, 2'd0, 2'd1, 2'd0, 6'h2A);
    load(16'hFFFF);
    xfer(1'b0, 8'h00, 1'b0);
    xfer(1'b1, 8'h77, 1'b0);

    // Random mix
    for (int i = 0; i < 200; i++) begin
      set_cfg(1'($urandom), 2'($urandom % 3), 1'($urandom), 1'($urandom), 2'($urandom % 3),
              2'($urandom), 2'($urandom), 2'($urandom), 6'($urandom));
      if ($urandom % 8 == 0) load(16'($urandom));
      xfer(1'($urandom), 8'($urandom), 1'($urandom % 4 == 0));
    end
    finish_run();
  end

endmodule